// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is a small register-transfer datapath with four general registers, an address register and a data register. All six hang off one internal bus, which is a multiplexer. Each cycle a command can carry up to two transfer slots. Each slot names one bus source and a mask of destination registers to load. A further opcode asks for a memory read or write. The bus has exactly one driver per cycle, so two valid slots must agree on their source. When they do, their destination masks are merged and every named register takes the same bus value at the clock edge.

Memory traffic goes only through the address and data registers. A write stores the data register into the word selected by the address register. A read loads that word into the data register. Both registers also sit on the bus, so they can be loaded from any source and can drive the bus. An extra bus source brings a word in from outside the block. Any request that breaks the bus or memory rules is dropped as a whole and raises an error flag for one cycle.

Top module: `xfer_bus_dp`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four general registers, the address register, the data register and the error flag. Memory contents are not cleared.
- R2: Source codes are 0 to 3 for general registers 0 to 3, 4 for the address register, 5 for the data register and 6 for `extData`. Destination mask bits 0 to 3 load general registers 0 to 3, bit 4 loads the address register and bit 5 loads the data register. A load is visible on the outputs after the clock edge that accepts it. The address register drives the bus zero-extended. A slot whose valid bit is low has no effect, whatever its fields hold.
- R3: One source may load several destinations in the same cycle, and all of them receive the same value.
- R4: Two valid slots naming the same source are accepted. The registers named in either mask are loaded.
- R5: Two valid slots naming different sources are rejected. This includes two sources aimed at the same destination. A rejected command changes no register and no memory word, and `errFlag` is 1 after that edge.
- R6: A valid slot with source code 7 is rejected, and so is memory opcode 3.
- R7: Memory opcode 1 (read) loads the word at the current address register into the data register. The value is visible after the edge.
- R8: Memory opcode 2 (write) stores the data register into the word at the address register. It uses the values held before the edge, so an address register load in the same cycle does not move the write.
- R9: A memory read or write in the same cycle as a bus load of the data register is rejected.
- R10: `errFlag` returns to 0 after any accepted command.
- R11: A memory operation and a bus transfer to other registers in the same cycle both take effect. The bus sees the old data register value while a read replaces it.
- R12: A cycle with no valid slot and memory opcode 0 leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slotAValid | input | 1 | Transfer slot A is present |
| slotASrc | input | 3 | Slot A bus source code |
| slotADst | input | 6 | Slot A destination load mask |
| slotBValid | input | 1 | Transfer slot B is present |
| slotBSrc | input | 3 | Slot B bus source code |
| slotBDst | input | 6 | Slot B destination load mask |
| memOp | input | 2 | 0 none, 1 read, 2 write, 3 illegal |
| extData | input | 8 | Word driven onto the bus by source code 6 |
| busData | output | 8 | Current internal bus value |
| gprFlat | output | 32 | General registers, register i in bits 8i+7..8i |
| arQ | output | 8 | Address register |
| drQ | output | 8 | Data register |
| errFlag | output | 1 | Previous command was rejected |

## Verification
The bench builds the block with its defaults: four general registers, an 8-bit data path and an 8-bit address. With these values the 3-bit source field is full except for one spare code, so the illegal-code rejection can be reached. The whole 256-word memory is also addressable, so writes to two separate words can be read back through the address and data registers. With equal address and data widths, the address register can be loaded from the bus and can drive it without truncation, and the bench relies on both.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    MEM_IDLE  = 2'd0,
    MEM_READ  = 2'd1,
    MEM_WRITE = 2'd2,
    MEM_BAD   = 2'd3
  } memOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic memWr;
    logic memRd;
    logic reject;
  } strobe_t;

endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int NUM_GPR = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        aValid,
  input  logic [$clog2(NUM_GPR+3)-1:0] aSrc,
  input  logic [NUM_GPR+1:0]          aDst,
  input  logic                        bValid,
  input  logic [$clog2(NUM_GPR+3)-1:0] bSrc,
  input  logic [NUM_GPR+1:0]          bDst,
  input  logic [1:0]                  memOp,
  output logic [$clog2(NUM_GPR+3)-1:0] busSel,
  output logic [NUM_GPR+1:0]          loadMask,
  output strobe_t                     strobe
);

  localparam int SRC_W  = $clog2(NUM_GPR + 3);
  localparam int DST_W  = NUM_GPR + 2;
  localparam int DR_IDX = NUM_GPR + 1;
  localparam logic [SRC_W-1:0] EXT_CODE = SRC_W'(NUM_GPR + 2);

  logic            aBad, bBad, srcClash, opBad, drClash, rejectC;
  logic            isRd, isWr;
  logic [DST_W-1:0] mergedMask;

  always_comb begin
    aBad       = aValid && (aSrc > EXT_CODE);
    bBad       = bValid && (bSrc > EXT_CODE);
    srcClash   = aValid && bValid && (aSrc != bSrc);
    mergedMask = (aValid ? aDst : '0) | (bValid ? bDst : '0);
    isRd       = (memOp == MEM_READ);
    isWr       = (memOp == MEM_WRITE);
    opBad      = (memOp == MEM_BAD);
    drClash    = (isRd || isWr) && mergedMask[DR_IDX];
    rejectC    = aBad || bBad || srcClash || opBad || drClash;

    busSel        = aValid ? aSrc : bSrc;
    loadMask      = rejectC ? '0 : mergedMask;
    strobe.reject = rejectC;
    strobe.memRd  = !rejectC && isRd;
    strobe.memWr  = !rejectC && isWr;
  end

  // R4
  mergeOk_chk: assert property (@(posedge clk) disable iff (rst)
    (aValid && bValid && aSrc == bSrc && aSrc <= EXT_CODE && memOp == MEM_IDLE)
      |-> !strobe.reject);

  // R5
  clashDrop_chk: assert property (@(posedge clk) disable iff (rst)
    (aValid && bValid && aSrc != bSrc)
      |-> (loadMask == '0 && !strobe.memWr && !strobe.memRd));

  // R9
  drConflict_chk: assert property (@(posedge clk) disable iff (rst)
    (memOp == MEM_WRITE && aValid && aDst[DR_IDX]) |-> !strobe.memWr);

endmodule

// File: rtl/xfer_dp.sv
module xfer_dp
  import xfer_pkg::*;
#(
  parameter int NUM_GPR = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [$clog2(NUM_GPR+3)-1:0]     busSel,
  input  logic [NUM_GPR+1:0]               loadMask,
  input  strobe_t                          strobe,
  input  logic [DATA_W-1:0]                extData,
  output logic [DATA_W-1:0]                busData,
  output logic [NUM_GPR-1:0][DATA_W-1:0]   gprQ,
  output logic [ADDR_W-1:0]                arQ,
  output logic [DATA_W-1:0]                drQ,
  output logic                             errQ
);

  localparam int SRC_W  = $clog2(NUM_GPR + 3);
  localparam int AR_IDX = NUM_GPR;
  localparam int DR_IDX = NUM_GPR + 1;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [SRC_W-1:0] AR_CODE  = SRC_W'(NUM_GPR);
  localparam logic [SRC_W-1:0] DR_CODE  = SRC_W'(NUM_GPR + 1);
  localparam logic [SRC_W-1:0] EXT_CODE = SRC_W'(NUM_GPR + 2);

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] memRdData;

  // Bus multiplexer
  always_comb begin
    busData = '0;
    for (int i = 0; i < NUM_GPR; i++) begin
      if (busSel == SRC_W'(i)) busData = gprQ[i];
    end
    if (busSel == AR_CODE)  busData = DATA_W'(arQ);
    if (busSel == DR_CODE)  busData = drQ;
    if (busSel == EXT_CODE) busData = extData;
  end

  assign memRdData = memArr[arQ];

  for (genvar g = 0; g < NUM_GPR; g++) begin : gGpr
    always_ff @(posedge clk) begin
      if (rst)              gprQ[g] <= '0;
      else if (loadMask[g]) gprQ[g] <= busData;
    end

    // R2
    gprLoad_chk: assert property (@(posedge clk) disable iff (rst)
      loadMask[g] |=> gprQ[g] == $past(busData));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arQ  <= '0;
      drQ  <= '0;
      errQ <= 1'b0;
    end else begin
      errQ <= strobe.reject;
      if (loadMask[AR_IDX]) arQ <= busData[ADDR_W-1:0];
      if (loadMask[DR_IDX])  drQ <= busData;
      else if (strobe.memRd) drQ <= memRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.memWr) memArr[arQ] <= drQ;
  end

  // R5
  rejectHold_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.reject |=> ($stable(gprQ) && $stable(arQ) && $stable(drQ)));

  // R7
  memRead_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.memRd |=> drQ == $past(memRdData));

  // R8
  memWrite_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.memWr |=> memArr[$past(arQ)] == $past(drQ));

endmodule

// File: rtl/xfer_bus_dp.sv
module xfer_bus_dp
  import xfer_pkg::*;
#(
  parameter int NUM_GPR = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           slotAValid,
  input  logic [$clog2(NUM_GPR+3)-1:0]   slotASrc,
  input  logic [NUM_GPR+1:0]             slotADst,
  input  logic                           slotBValid,
  input  logic [$clog2(NUM_GPR+3)-1:0]   slotBSrc,
  input  logic [NUM_GPR+1:0]             slotBDst,
  input  logic [1:0]                     memOp,
  input  logic [DATA_W-1:0]              extData,
  output logic [DATA_W-1:0]              busData,
  output logic [NUM_GPR*DATA_W-1:0]      gprFlat,
  output logic [ADDR_W-1:0]              arQ,
  output logic [DATA_W-1:0]              drQ,
  output logic                           errFlag
);

  localparam int SRC_W = $clog2(NUM_GPR + 3);
  localparam int DST_W = NUM_GPR + 2;

  logic [SRC_W-1:0]                 busSel;
  logic [DST_W-1:0]                 loadMask;
  strobe_t                          strobe;
  logic [NUM_GPR-1:0][DATA_W-1:0]   gprQ;

  xfer_ctrl #(.NUM_GPR(NUM_GPR)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .aValid   (slotAValid),
    .aSrc     (slotASrc),
    .aDst     (slotADst),
    .bValid   (slotBValid),
    .bSrc     (slotBSrc),
    .bDst     (slotBDst),
    .memOp    (memOp),
    .busSel   (busSel),
    .loadMask (loadMask),
    .strobe   (strobe)
  );

  xfer_dp #(.NUM_GPR(NUM_GPR), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .busSel   (busSel),
    .loadMask (loadMask),
    .strobe   (strobe),
    .extData  (extData),
    .busData  (busData),
    .gprQ     (gprQ),
    .arQ      (arQ),
    .drQ      (drQ),
    .errQ     (errFlag)
  );

  assign gprFlat = gprQ;

endmodule

// File: tb/xfer_bus_dp_tb.sv
module xfer_bus_dp_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slotAValid = 1'b0, slotBValid = 1'b0;
  logic [2:0] slotASrc = '0, slotBSrc = '0;
  logic [5:0] slotADst = '0, slotBDst = '0;
  logic [1:0] memOp = '0;
  logic [7:0] extData = '0;
  logic [7:0] busData, arQ, drQ;
  logic [31:0] gprFlat;
  logic       errFlag;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xfer_bus_dp u_dut (
    .clk(clk), .rst(rst),
    .slotAValid(slotAValid), .slotASrc(slotASrc), .slotADst(slotADst),
    .slotBValid(slotBValid), .slotBSrc(slotBSrc), .slotBDst(slotBDst),
    .memOp(memOp), .extData(extData), .busData(busData),
    .gprFlat(gprFlat), .arQ(arQ), .drQ(drQ), .errFlag(errFlag)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       aV; logic [2:0] aS; logic [5:0] aD;
    logic       bV; logic [2:0] bS; logic [5:0] bD;
    logic [1:0] op; logic [7:0] ext; logic expErr;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    {4'd2,  1'b1,3'd6,6'b000001, 1'b0,3'd0,6'b000000, 2'd0, 8'h11, 1'b0}, // R2 ext->gpr0
    {4'd2,  1'b1,3'd6,6'b000010, 1'b0,3'd0,6'b000000, 2'd0, 8'h22, 1'b0}, // R2 ext->gpr1
    {4'd3,  1'b1,3'd6,6'b001100, 1'b0,3'd0,6'b000000, 2'd0, 8'h33, 1'b0}, // R3 fan-out
    {4'd4,  1'b1,3'd2,6'b000001, 1'b1,3'd2,6'b110000, 2'd0, 8'h00, 1'b0}, // R4 merge
    {4'd5,  1'b1,3'd1,6'b000100, 1'b1,3'd0,6'b001000, 2'd0, 8'h00, 1'b1}, // R5 two sources
    {4'd5,  1'b1,3'd0,6'b001000, 1'b1,3'd1,6'b001000, 2'd0, 8'h00, 1'b1}, // R5 same dest
    {4'd6,  1'b1,3'd7,6'b000001, 1'b0,3'd0,6'b000000, 2'd0, 8'h00, 1'b1}, // R6 bad code
    {4'd6,  1'b0,3'd0,6'b000000, 1'b0,3'd0,6'b000000, 2'd3, 8'h00, 1'b1}, // R6 bad opcode
    {4'd8,  1'b1,3'd1,6'b010000, 1'b0,3'd0,6'b000000, 2'd2, 8'h00, 1'b0}, // R8 write, AR reload
    {4'd2,  1'b1,3'd6,6'b100000, 1'b0,3'd0,6'b000000, 2'd0, 8'h44, 1'b0}, // R2 ext->DR
    {4'd8,  1'b0,3'd0,6'b000000, 1'b0,3'd0,6'b000000, 2'd2, 8'h00, 1'b0}, // R8 write
    {4'd9,  1'b1,3'd6,6'b100000, 1'b0,3'd0,6'b000000, 2'd2, 8'h55, 1'b1}, // R9 write+DR load
    {4'd9,  1'b1,3'd6,6'b100000, 1'b0,3'd0,6'b000000, 2'd1, 8'h55, 1'b1}, // R9 read+DR load
    {4'd2,  1'b1,3'd6,6'b010000, 1'b0,3'd0,6'b000000, 2'd0, 8'h33, 1'b0}, // R2 ext->AR
    {4'd11, 1'b1,3'd5,6'b000010, 1'b0,3'd0,6'b000000, 2'd1, 8'h00, 1'b0}, // R11 read + DR->gpr1
    {4'd2,  1'b1,3'd4,6'b000001, 1'b0,3'd0,6'b000000, 2'd0, 8'h00, 1'b0}, // R2 AR->gpr0
    {4'd2,  1'b1,3'd6,6'b010000, 1'b0,3'd0,6'b000000, 2'd0, 8'h22, 1'b0}, // R2 ext->AR
    {4'd7,  1'b0,3'd0,6'b000000, 1'b0,3'd0,6'b000000, 2'd1, 8'h00, 1'b0}, // R7 read
    {4'd12, 1'b0,3'd6,6'b111111, 1'b0,3'd6,6'b111111, 2'd0, 8'hFF, 1'b0}, // R12 idle
    {4'd2,  1'b0,3'd0,6'b000000, 1'b1,3'd6,6'b000100, 2'd0, 8'h5A, 1'b0}  // R2 slot B alone
  };

  // Reference model built from the requirements
  logic [7:0] mGpr [4];
  logic [7:0] mAr, mDr;
  logic [7:0] mMem [256];
  logic       mErr;

  task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input int req);
    for (int i = 0; i < 4; i++) chk(req, $sformatf("gpr%0d", i), gprFlat[8*i +: 8], mGpr[i]);
    chk(req, "addr reg", arQ, mAr);
    chk(req, "data reg", drQ, mDr);
    chk(req, "error flag", {7'd0, errFlag}, {7'd0, mErr});
  endtask

  task automatic modelReset();
    for (int i = 0; i < 4; i++) mGpr[i] = '0;
    mAr = '0; mDr = '0; mErr = 1'b0;
  endtask

  task automatic modelStep(input vec_t v);
    logic [2:0] src;
    logic [5:0] msk;
    logic [7:0] bus, oldAr, oldDr;
    mErr = v.expErr;
    if (!v.expErr) begin
      src = v.aV ? v.aS : v.bS;
      msk = (v.aV ? v.aD : 6'd0) | (v.bV ? v.bD : 6'd0);
      oldAr = mAr; oldDr = mDr;
      case (src)
        3'd4:    bus = oldAr;
        3'd5:    bus = oldDr;
        3'd6:    bus = v.ext;
        default: bus = mGpr[src[1:0]];
      endcase
      for (int i = 0; i < 4; i++) if (msk[i]) mGpr[i] = bus;
      if (msk[4]) mAr = bus;
      if (msk[5]) mDr = bus;
      else if (v.op == 2'd1) mDr = mMem[oldAr];
      if (v.op == 2'd2) mMem[oldAr] = oldDr;
    end
  endtask

  task automatic drive(input vec_t v);
    slotAValid = v.aV; slotASrc = v.aS; slotADst = v.aD;
    slotBValid = v.bV; slotBSrc = v.bS; slotBDst = v.bD;
    memOp = v.op; extData = v.ext;
  endtask

  task automatic idle();
    slotAValid = 1'b0; slotBValid = 1'b0; memOp = 2'd0;
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    // R1: state right after reset
    checkAll(1);
    rst = 1'b0;

    // Vector walk: drive at negedge, check at the following negedge
    for (int k = 0; k < NV; k++) begin
      drive(VECS[k]);
      @(negedge clk);
      modelStep(VECS[k]);
      checkAll(int'(VECS[k].req));
    end

    // R10: error set then cleared by an accepted idle cycle
    drive(VECS[4]);
    @(negedge clk);
    modelStep(VECS[4]);
    chk(5, "error after clash", {7'd0, errFlag}, 8'd1);
    idle();
    @(negedge clk);
    mErr = 1'b0;
    chk(10, "error cleared", {7'd0, errFlag}, 8'd0);

    // R8 check through R7: address 0x33 holds the value written in vector 8
    drive('{req:4'd2, aV:1'b1, aS:3'd6, aD:6'b010000, bV:1'b0, bS:3'd0, bD:6'd0,
            op:2'd0, ext:8'h33, expErr:1'b0});
    @(negedge clk);
    mAr = 8'h33;
    drive('{req:4'd7, aV:1'b0, aS:3'd0, aD:6'd0, bV:1'b0, bS:3'd0, bD:6'd0,
            op:2'd1, ext:8'h00, expErr:1'b0});
    @(negedge clk);
    mDr = mMem[8'h33];
    chk(8, "write used old address", drQ, 8'h33);

    // R1: reset mid-run while the error flag is set
    drive(VECS[6]);
    @(negedge clk);
    modelStep(VECS[6]);
    idle();
    rst = 1'b1;
    @(negedge clk);
    modelReset();
    checkAll(1);
    rst = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule